// File: doc/BRIEF.md
# GPIO Port with Peripheral Multiplexing

This block controls a 32-pin general-purpose I/O port from a simple word-addressed register bus. Software sets output values and directions either by writing the whole register or through write-one-to-set and write-one-to-clear aliases. These aliases let one pin change without a read-modify-write. Each pin has a small configuration field: peripheral routing, input buffer, pull resistor and drive strength. A packed table of 4-bit selections, two pins to a register, picks which peripheral function owns a routed pin. The pad-control outputs come directly from this state.

Pad inputs pass through a synchronizer before they can be read. A per-pin control bit chooses between two modes. In continuous mode the pin is sampled every cycle, so a read of the input register completes at once. In on-demand mode the pin is sampled only while a read of the input register is pending. That read holds off its acknowledge until a fresh value has travelled through the synchronizer.

Top module: `gpio_port_mux`

## Requirements
- R1: After reset every register reads 0. Every pad-control output is 0, so all pins are inputs with input buffer, pull and routing off, and every pin is in on-demand sampling mode.
- R2: Word address 0 holds the output-value register and word address 3 holds the direction register. A write replaces the whole register and a read returns it. A direction bit of 1 makes the pin drive.
- R3: A write to address 1 sets every output bit where the write data is 1. A write to address 2 clears every output bit where the write data is 1. Bits written as 0 keep their value, and a read of either address returns the output-value register.
- R4: Addresses 4 and 5 behave the same way on the direction register, setting and clearing respectively. A read of either address returns the direction register.
- R5: Address 32+p holds the configuration of pin p in data bits 3:0. Bit 0 is peripheral routing, bit 1 is input enable, bit 2 is pull enable and bit 3 is strong drive. Data bits 31:4 are not stored and read as 0.
- R6: `pad_pull_en_o[p]` follows the pull-enable flag of pin p. `pad_pull_up_o[p]` is 1 only when pull is enabled and output bit p is 1. Pull enabled with output bit 0 means pull-down.
- R7: Address 16+k holds the selections for pin 2k in bits 3:0 and for pin 2k+1 in bits 7:4. Bits 31:8 read 0. `pad_mux_sel_o[4p+3:4p]` carries the selection of pin p.
- R8: When pin p has routing set, `pad_mux_en_o[p]` is 1 and `pad_oe_o[p]` and `pad_out_o[p]` are 0 whatever the direction and output bits hold. When routing is clear, `pad_oe_o[p]` equals direction bit p and `pad_out_o[p]` equals output bit p.
- R9: `pad_ie_o[p]` equals the input-enable flag of pin p. A pin whose input enable is clear reads as 0 at address 6, the input register.
- R10: Address 7 holds the sampling-mode register, where 1 means continuous. When all 32 bits are 1, a read of address 6 is acknowledged in its first cycle. It returns each input-enabled pad value that has been stable for at least three cycles.
- R11: When any sampling-mode bit is 0, a read of address 6 is acknowledged only after three wait cycles, in its fourth cycle. It returns the pad values present in the first cycle of the request.
- R12: Writes are acknowledged in the cycle they are requested. Writes to address 6 or to unmapped addresses change nothing, and reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus request, held until ack_o |
| we_i | input | 1 | 1 for write, 0 for read |
| addr_i | input | 6 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid while ack_o is high |
| ack_o | output | 1 | Request completes this cycle |
| pad_in_i | input | 32 | Asynchronous pad input levels |
| pad_oe_o | output | 32 | Port drives the pad |
| pad_out_o | output | 32 | Value driven by the port |
| pad_pull_en_o | output | 32 | Pull resistor enabled |
| pad_pull_up_o | output | 32 | Pull direction, 1 = up |
| pad_drive_o | output | 32 | Strong drive |
| pad_ie_o | output | 32 | Input buffer enabled |
| pad_mux_en_o | output | 32 | Pad owned by the selected peripheral |
| pad_mux_sel_o | output | 128 | 4-bit peripheral selection per pin |

## Verification
The bench targets the alias writes with mixed one and zero bits. An alias that wrote its data instead of merging it would corrupt pins the write never named. It toggles the output bit under an enabled pull, where a fixed pull direction would show up on `pad_pull_up_o`. It enables routing on a pin that is set to drive high, where a design that ignored the routing would keep driving the pad. It also counts the wait cycles of input reads in both sampling modes and changes the pad just as an on-demand read starts. A design that returned stale synchronizer contents, or acknowledged early, would give the wrong value or the wrong count.

// File: rtl/gpio_pkg.sv
`timescale 1ns/1ps
package gpio_pkg;
  localparam int unsigned AW = 6;
  localparam int unsigned DW = 32;

  localparam logic [AW-1:0] A_OUT    = 6'd0;
  localparam logic [AW-1:0] A_OUTSET = 6'd1;
  localparam logic [AW-1:0] A_OUTCLR = 6'd2;
  localparam logic [AW-1:0] A_DIR    = 6'd3;
  localparam logic [AW-1:0] A_DIRSET = 6'd4;
  localparam logic [AW-1:0] A_DIRCLR = 6'd5;
  localparam logic [AW-1:0] A_IN     = 6'd6;
  localparam logic [AW-1:0] A_SMODE  = 6'd7;
  localparam int unsigned   A_MUX0   = 16;
  localparam int unsigned   A_CFG0   = 32;

  typedef struct packed {
    logic drv;
    logic pull;
    logic inen;
    logic route;
  } pin_cfg_t;
endpackage

// File: rtl/gpio_regs.sv
`timescale 1ns/1ps
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_i,
  input  logic [AW-1:0]         addr_i,
  input  logic [DW-1:0]         wdata_i,
  output logic [DW-1:0]         rd_data_o,
  output logic [NPINS-1:0]      out_o,
  output logic [NPINS-1:0]      dir_o,
  output logic [NPINS-1:0]      smode_o,
  output pin_cfg_t [NPINS-1:0]  cfg_o,
  output logic [4*NPINS-1:0]    sel_o
);
  localparam int unsigned NMUX = NPINS / 2;

  logic [NPINS-1:0] out_q, dir_q, smode_q;
  logic [NPINS-1:0] wd;
  pin_cfg_t         cfg_q [NPINS];
  logic [7:0]       mux_q [NMUX];

  assign wd = wdata_i[NPINS-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q   <= '0;
      dir_q   <= '0;
      smode_q <= '0;
    end else if (wr_i) begin
      case (addr_i)
        A_OUT:    out_q   <= wd;
        A_OUTSET: out_q   <= out_q | wd;
        A_OUTCLR: out_q   <= out_q & ~wd;
        A_DIR:    dir_q   <= wd;
        A_DIRSET: dir_q   <= dir_q | wd;
        A_DIRCLR: dir_q   <= dir_q & ~wd;
        A_SMODE:  smode_q <= wd;
        default: ;
      endcase
    end
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_cfg
    localparam logic [AW-1:0] CA = AW'(A_CFG0 + p);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                   cfg_q[p] <= '0;
      else if (wr_i && addr_i == CA) cfg_q[p] <= wdata_i[3:0];
    end
    assign cfg_o[p] = cfg_q[p];
    assign sel_o[4*p +: 4] = mux_q[p/2][4*(p%2) +: 4];
  end

  for (genvar k = 0; k < NMUX; k++) begin : g_mux
    localparam logic [AW-1:0] MA = AW'(A_MUX0 + k);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                   mux_q[k] <= '0;
      else if (wr_i && addr_i == MA) mux_q[k] <= wdata_i[7:0];
    end
  end

  always_comb begin
    rd_data_o = '0;
    case (addr_i)
      A_OUT, A_OUTSET, A_OUTCLR: rd_data_o[NPINS-1:0] = out_q;
      A_DIR, A_DIRSET, A_DIRCLR: rd_data_o[NPINS-1:0] = dir_q;
      A_SMODE:                   rd_data_o[NPINS-1:0] = smode_q;
      default: ;
    endcase
    for (int p = 0; p < NPINS; p++)
      if (addr_i == AW'(A_CFG0 + p)) rd_data_o[3:0] = cfg_q[p];
    for (int k = 0; k < NMUX; k++)
      if (addr_i == AW'(A_MUX0 + k)) rd_data_o[7:0] = mux_q[k];
  end

  assign out_o   = out_q;
  assign dir_o   = dir_q;
  assign smode_o = smode_q;

  a_r3_set_hits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == A_OUTSET) |=> ((out_q & $past(wd)) == $past(wd)))
    else $error("R3 set alias missed a bit");
  a_r3_clr_hits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == A_OUTCLR) |=> ((out_q & $past(wd)) == '0))
    else $error("R3 clear alias missed a bit");
  a_r4_dirset_hits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == A_DIRSET) |=> ((dir_q & $past(wd)) == $past(wd)))
    else $error("R4 direction set alias missed a bit");
endmodule

// File: rtl/gpio_sampler.sv
`timescale 1ns/1ps
module gpio_sampler #(
  parameter int unsigned NPINS       = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] pad_i,
  input  logic [NPINS-1:0] smode_i,
  input  logic             req_i,
  input  logic             rd_in_i,
  output logic [NPINS-1:0] in_o,
  output logic             ack_o
);
  localparam int unsigned LAT = SYNC_STAGES + 1;
  localparam int unsigned CW  = $clog2(LAT + 1);

  logic [CW-1:0]    cnt_q;
  logic             need_wait;
  logic [NPINS-1:0] en;
  logic [NPINS-1:0] sq [SYNC_STAGES];
  logic [NPINS-1:0] in_q;

  assign need_wait = ~&smode_i;
  assign en        = smode_i | {NPINS{rd_in_i}};
  assign ack_o     = req_i & (~rd_in_i | ~need_wait | (cnt_q == CW'(LAT)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (rd_in_i && !ack_o)  cnt_q <= cnt_q + 1'b1;
    else                         cnt_q <= '0;
  end

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    logic [NPINS-1:0] src;
    if (s == 0) begin : g_first
      assign src = pad_i;
    end else begin : g_next
      assign src = sq[s-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sq[s] <= '0;
      else         sq[s] <= (sq[s] & ~en) | (src & en);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) in_q <= '0;
    else         in_q <= (in_q & ~en) | (sq[SYNC_STAGES-1] & en);
  end

  assign in_o = in_q;

  // on-demand read can never finish in its first cycle
  a_r11_no_first_cycle_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(rd_in_i) && need_wait) |-> !ack_o)
    else $error("R11 on-demand read acknowledged early");
endmodule

// File: rtl/gpio_pad_ctl.sv
`timescale 1ns/1ps
module gpio_pad_ctl
  import gpio_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic [NPINS-1:0]     out_i,
  input  logic [NPINS-1:0]     dir_i,
  input  pin_cfg_t [NPINS-1:0] cfg_i,
  output logic [NPINS-1:0]     oe_o,
  output logic [NPINS-1:0]     val_o,
  output logic [NPINS-1:0]     pull_en_o,
  output logic [NPINS-1:0]     pull_up_o,
  output logic [NPINS-1:0]     drive_o,
  output logic [NPINS-1:0]     ie_o,
  output logic [NPINS-1:0]     route_o
);
  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    assign route_o[p]   = cfg_i[p].route;
    assign oe_o[p]      = dir_i[p] & ~cfg_i[p].route;
    assign val_o[p]     = out_i[p] & ~cfg_i[p].route;
    assign pull_en_o[p] = cfg_i[p].pull;
    assign pull_up_o[p] = cfg_i[p].pull & out_i[p];
    assign drive_o[p]   = cfg_i[p].drv;
    assign ie_o[p]      = cfg_i[p].inen;
  end
endmodule

// File: rtl/gpio_port_mux.sv
`timescale 1ns/1ps
module gpio_port_mux
  import gpio_pkg::*;
#(
  parameter int unsigned NPINS       = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [5:0]          addr_i,
  input  logic [31:0]         wdata_i,
  output logic [31:0]         rdata_o,
  output logic                ack_o,
  input  logic [NPINS-1:0]    pad_in_i,
  output logic [NPINS-1:0]    pad_oe_o,
  output logic [NPINS-1:0]    pad_out_o,
  output logic [NPINS-1:0]    pad_pull_en_o,
  output logic [NPINS-1:0]    pad_pull_up_o,
  output logic [NPINS-1:0]    pad_drive_o,
  output logic [NPINS-1:0]    pad_ie_o,
  output logic [NPINS-1:0]    pad_mux_en_o,
  output logic [4*NPINS-1:0]  pad_mux_sel_o
);
  logic                 wr, rd_in;
  logic [DW-1:0]        reg_rd;
  logic [NPINS-1:0]     out_q, dir_q, smode_q, in_q;
  pin_cfg_t [NPINS-1:0] cfg;

  assign wr    = req_i & we_i;
  assign rd_in = req_i & ~we_i & (addr_i == A_IN);

  gpio_regs #(.NPINS(NPINS)) u_regs (
    .clk_i, .rst_ni, .wr_i(wr), .addr_i, .wdata_i, .rd_data_o(reg_rd),
    .out_o(out_q), .dir_o(dir_q), .smode_o(smode_q), .cfg_o(cfg),
    .sel_o(pad_mux_sel_o)
  );

  gpio_sampler #(.NPINS(NPINS), .SYNC_STAGES(SYNC_STAGES)) u_samp (
    .clk_i, .rst_ni, .pad_i(pad_in_i), .smode_i(smode_q), .req_i,
    .rd_in_i(rd_in), .in_o(in_q), .ack_o
  );

  gpio_pad_ctl #(.NPINS(NPINS)) u_pad (
    .out_i(out_q), .dir_i(dir_q), .cfg_i(cfg),
    .oe_o(pad_oe_o), .val_o(pad_out_o), .pull_en_o(pad_pull_en_o),
    .pull_up_o(pad_pull_up_o), .drive_o(pad_drive_o), .ie_o(pad_ie_o),
    .route_o(pad_mux_en_o)
  );

  always_comb begin
    rdata_o = reg_rd;
    if (addr_i == A_IN) begin
      rdata_o = '0;
      rdata_o[NPINS-1:0] = in_q & pad_ie_o;
    end
  end

  a_r12_write_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i) |-> ack_o)
    else $error("R12 write not acknowledged at once");
  a_r8_routed_not_driven: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o & pad_mux_en_o) == '0)
    else $error("R8 routed pin still driven by port");
endmodule

// File: tb/sim_gpio_port_mux.sv
`timescale 1ns/1ps
module sim_gpio_port_mux;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0, rdata, pad_in = '0;
  logic ack;
  logic [31:0] oe, pout, pen, pup, drv, ie, men;
  logic [127:0] msel;

  int nchk = 0, nerr = 0;
  logic [31:0] out_m = '0, dir_m = '0, smode_m = '0;
  logic [3:0]  cfg_m [32];
  logic [7:0]  mux_m [16];

  always #10 clk = ~clk;

  gpio_port_mux u0 (
    .clk_i(clk), .rst_ni, .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .ack_o(ack), .pad_in_i(pad_in), .pad_oe_o(oe), .pad_out_o(pout),
    .pad_pull_en_o(pen), .pad_pull_up_o(pup), .pad_drive_o(drv), .pad_ie_o(ie),
    .pad_mux_en_o(men), .pad_mux_sel_o(msel)
  );

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] flag(input int b);
    logic [31:0] v;
    for (int p = 0; p < 32; p++) v[p] = cfg_m[p][b];
    return v;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [5:0] a);
    int ia = int'(a);
    if (ia <= 2) return out_m;
    if (ia <= 5) return dir_m;
    if (ia == 7) return smode_m;
    if (ia >= 32) return {28'd0, cfg_m[ia-32]};
    if (ia >= 16) return {24'd0, mux_m[ia-16]};
    return '0;
  endfunction

  // per-cycle pad comparison against the model
  always @(negedge clk) if (rst_ni) begin
    logic [127:0] es;
    for (int p = 0; p < 32; p++) es[4*p +: 4] = mux_m[p/2][4*(p%2) +: 4];
    check("R8 oe",      oe,   dir_m & ~flag(0));
    check("R8 out",     pout, out_m & ~flag(0));
    check("R8 route",   men,  flag(0));
    check("R9 ie",      ie,   flag(1));
    check("R6 pull_en", pen,  flag(2));
    check("R6 pull_up", pup,  flag(2) & out_m);
    check("R5 drive",   drv,  flag(3));
    check("R7 sel",     msel, es);
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    int ia = int'(a);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    #1 check("R12 write ack", ack, 1'b1);
    @(posedge clk);
    case (ia)
      0: out_m = d;
      1: out_m = out_m | d;
      2: out_m = out_m & ~d;
      3: dir_m = d;
      4: dir_m = dir_m | d;
      5: dir_m = dir_m & ~d;
      7: smode_m = d;
      default: begin
        if (ia >= 32) cfg_m[ia-32] = d[3:0];
        else if (ia >= 16) mux_m[ia-16] = d[7:0];
      end
    endcase
    #1 req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d, output int waits);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a; waits = 0;
    #1;
    while (!ack && waits < 10) begin
      @(negedge clk); #1; waits++;
    end
    d = rdata;
    @(posedge clk); #1 req = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [5:0] a);
    logic [31:0] d; int w;
    rd(a, d, w);
    check(tag, d, exp_rd(a));
  endtask

  initial begin
    #4_000_000;
    nerr++;
    $display("FAIL watchdog act=hung exp=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [31:0] d; int w;
    for (int p = 0; p < 32; p++) cfg_m[p] = '0;
    for (int k = 0; k < 16; k++) mux_m[k] = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset state
    rd_chk("R1 out", 6'd0);  rd_chk("R1 dir", 6'd3);  rd_chk("R1 smode", 6'd7);
    rd_chk("R1 cfg", 6'd37); rd_chk("R1 mux", 6'd19);
    check("R1 pads", {oe, pout, pen, ie, men}, '0);
    // R2 full writes
    wr(6'd0, 32'hA5A5_0F0F); rd_chk("R2 out", 6'd0);
    wr(6'd3, 32'h0000_FFFF); rd_chk("R2 dir", 6'd3);
    // R3 set/clear aliases
    wr(6'd1, 32'h1000_0030); rd_chk("R3 set", 6'd0);
    wr(6'd2, 32'h0000_000F); rd_chk("R3 clr", 6'd0);
    rd_chk("R3 alias read", 6'd1); rd_chk("R3 clr alias read", 6'd2);
    // R4 direction aliases
    wr(6'd4, 32'hF000_0000); wr(6'd5, 32'h0000_00F0);
    rd_chk("R4 dir", 6'd3); rd_chk("R4 alias read", 6'd5);
    // R5 configuration bytes
    wr(6'd35, 32'hFFFF_FFFF); rd_chk("R5 cfg upper bits", 6'd35);
    wr(6'd32, 32'h0000_0004); rd_chk("R5 cfg pull", 6'd32);
    // R6 pull direction follows output bit 0
    wr(6'd1, 32'h1); @(negedge clk); check("R6 pull up", pup[0], 1'b1);
    wr(6'd2, 32'h1); @(negedge clk); check("R6 pull down", {pen[0], pup[0]}, 2'b10);
    // R7 mux table
    wr(6'd17, 32'h0000_03A7); rd_chk("R7 mux read", 6'd17);
    @(negedge clk); check("R7 pin2 sel", msel[11:8], 4'h7); check("R7 pin3 sel", msel[15:12], 4'hA);
    // R8 routing overrides direction and output
    wr(6'd4, 32'h8); wr(6'd1, 32'h8); @(negedge clk);
    check("R8 routed pin3", {oe[3], pout[3], men[3]}, 3'b001);
    wr(6'd35, 32'h0); @(negedge clk);
    check("R8 released pin3", {oe[3], pout[3], men[3]}, 3'b110);
    // R9 / R11 on-demand input reads
    for (int p = 8; p < 16; p++) wr(6'(32 + p), 32'h2);
    pad_in = 32'h1234_5678;
    rd(6'd6, d, w);
    check("R11 wait cycles", w, 3); check("R9 masked input", d, 32'h1234_5678 & flag(1));
    @(negedge clk); pad_in = 32'h0000_A500;
    rd(6'd6, d, w);
    check("R11 fresh sample", d, 32'h0000_A500 & flag(1)); check("R11 wait again", w, 3);
    // R10 continuous mode
    wr(6'd7, 32'hFFFF_FFFF); rd_chk("R10 smode read", 6'd7);
    pad_in = 32'hFFFF_5A00;
    repeat (4) @(negedge clk);
    rd(6'd6, d, w);
    check("R10 no wait", w, 0); check("R10 value", d, 32'hFFFF_5A00 & flag(1));
    // R12 ignored writes and unmapped reads
    wr(6'd6, 32'hFFFF_FFFF); rd(6'd6, d, w);
    check("R12 input write ignored", d, 32'hFFFF_5A00 & flag(1));
    wr(6'd10, 32'hFFFF_FFFF); rd_chk("R12 unmapped read", 6'd10);
    rd_chk("R12 out untouched", 6'd0); rd_chk("R12 dir untouched", 6'd3);
    wr(6'd7, 32'h7FFF_FFFF); rd(6'd6, d, w);
    check("R11 one on-demand pin", w, 3);
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule